// File: doc/BRIEF.md
# Boot-Time Clock Configuration Sequencer

This block runs once after reset and programs up to three clock chips over SPI: an RF reference clock buffer, a sampling clock buffer, and a PLL that sits on an optional plug-in clock module. It waits for a settling period and then samples three strap inputs: whether a module is present, whether that module is the PLL type or the connector-only type, and a two-position switch. From these it chooses one configuration set and the group of devices that receive it.

Each configuration table holds single-byte register writes stored as address/data byte pairs. The tables come from an external byte-wide EEPROM when a two-byte signature is found there. Otherwise they come from a default ROM inside the block. Each pair becomes one 16-bit SPI transfer to one chip select. When the last write has been acknowledged, the block raises `done` and keeps it high.

The EEPROM reader and the SPI shifter are outside the block. Both are reached through request/acknowledge ports.

Top module: `clkcfg_seq`

## Requirements
- R1: The inputs `mod_present`, `mod_is_pll` and `sw` are sampled once, on the SETTLE_CYC-th rising clock edge after reset is released. Any later change to them has no effect on the writes that are issued.
- R2: After sampling, the block reads EEPROM byte EE_BASE (default 15000) and then byte EE_BASE+1. The external tables are used only when these two bytes are 0xA5 and 0xCD. In any other case every table comes from the internal ROM, and no further EEPROM read is made.
- R3: Each table has a number t = dev*7 + cfg, where dev is 0 for RF, 1 for sampling and 2 for PLL. In the EEPROM, table t starts at EE_BASE + 2 + t*TBL_STRIDE and holds a count byte followed by that many (register address, data) byte pairs. These bytes are read in address order.
- R4: In the internal ROM, the count of table t is (t+1) mod 4. Pair k of that table has address dev*64 + cfg*8 + k and data equal to that address XOR 0x3C.
- R5: When no module is present, configuration 0 is written to RF, then sampling, then PLL.
- R6: With a connector-only module, switch 0 writes configuration 0 to all three devices. Switch values 1 to 3 write configuration 1 to 3 to the RF and sampling devices only. The PLL chip select is never driven in that case.
- R7: With a PLL module, switch 0 writes configuration 0 to all three devices. Switch values 1 to 3 write configuration 4 to 6 to all three devices, in RF, sampling, PLL order.
- R8: A table whose count is zero produces no SPI transfer for that device.
- R9: Each SPI transfer has the register address in `spi_word[15:8]` and the data in `spi_word[7:0]`. `spi_cs` is one-hot (bit 0 RF, bit 1 sampling, bit 2 PLL) while `spi_req` is high and all zero otherwise. Request, word and chip select stay stable until `spi_ack`, and only one transfer is outstanding at a time.
- R10: `ee_req` and `ee_addr` stay stable until `ee_ack`. The data is taken from `ee_data` in the cycle in which `ee_ack` is high.
- R11: `done` is low from reset until the last selected write is acknowledged. After that it stays high, and no further SPI or EEPROM request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_present | input | 1 | A clock module is fitted |
| mod_is_pll | input | 1 | The fitted module is the PLL type |
| sw | input | 2 | Module switch setting |
| ee_req | output | 1 | EEPROM byte read request |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_ack | input | 1 | Read complete, `ee_data` valid |
| ee_data | input | 8 | EEPROM read data |
| spi_req | output | 1 | SPI transfer request |
| spi_cs | output | 3 | One-hot device select |
| spi_word | output | 16 | Register address and data |
| spi_ack | input | 1 | Transfer accepted |
| done | output | 1 | All writes complete |

## Verification
Two events can land in the same clock cycle:

- the acknowledge that retires one SPI transfer and the decision that moves the sequencer to the next device, or to completion;
- the arrival of the table byte that fetching delivers and the start of the next fetch.

With both responders set to zero latency, these events fall back to back. A bench model then judges the outcome by comparing the full ordered list of transfers, and the EEPROM read count, against a list it builds from the requirements.

A separate trial moves the strap inputs just before and just after the sampling edge. In that trial only the values present at the edge may decide the device group.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int NUM_DEV = 3;
  localparam int CFG_PER_DEV = 7;
  localparam logic [2:0] CFG_NOMOD = 3'd0;
  localparam logic [2:0] CFG_PLL_BASE = 3'd3;

  typedef struct packed {
    logic [2:0] dev_mask;
    logic [2:0] cfg_id;
  } plan_t;

  // Selects the configuration id and the group of devices from the straps.
  function automatic plan_t choose_plan(input logic present, input logic is_pll,
                                        input logic [1:0] sw);
    plan_t p;
    p.dev_mask = 3'b111;
    p.cfg_id   = CFG_NOMOD;
    if (present && (sw != 2'b00)) begin
      if (is_pll) begin
        p.cfg_id = CFG_PLL_BASE + {1'b0, sw};
      end else begin
        p.cfg_id   = {1'b0, sw};
        p.dev_mask = 3'b011;
      end
    end
    return p;
  endfunction

  function automatic logic [4:0] table_index(input logic [1:0] dev, input logic [2:0] cfg);
    return ({3'b000, dev} * 5'd7) + {2'b00, cfg};
  endfunction

  function automatic logic [1:0] rom_count(input logic [4:0] tidx);
    logic [4:0] n;
    n = tidx + 5'd1;
    return n[1:0];
  endfunction

  // Default table byte at offset off: offset 0 is the count, then address/data pairs.
  function automatic logic [7:0] rom_byte(input logic [1:0] dev, input logic [2:0] cfg,
                                          input logic [15:0] off);
    logic [15:0] k;
    logic [7:0]  reg_a;
    if (off == 16'd0) return {6'b000000, rom_count(table_index(dev, cfg))};
    k     = (off - 16'd1) >> 1;
    reg_a = {dev, cfg, k[2:0]};
    return off[0] ? reg_a : (reg_a ^ 8'h3C);
  endfunction

endpackage

// File: rtl/clkcfg_plan.sv
module clkcfg_plan
  import clkcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       present,
  input  logic       is_pll,
  input  logic [1:0] sw,
  output plan_t      plan,
  output logic       valid
);

  logic       pres_q;
  logic       pll_q;
  logic [1:0] sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= 1'b0;
      pll_q  <= 1'b0;
      sw_q   <= 2'b00;
      valid  <= 1'b0;
    end else if (sample && !valid) begin
      pres_q <= present;
      pll_q  <= is_pll;
      sw_q   <= sw;
      valid  <= 1'b1;
    end
  end

  always_comb plan = choose_plan(pres_q, pll_q, sw_q);

endmodule

// File: rtl/clkcfg_fetch.sv
module clkcfg_fetch
  import clkcfg_pkg::*;
#(
  parameter int EE_AW = 16,
  parameter int OFF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_ee,
  input  logic [EE_AW-1:0] addr_in,
  input  logic [1:0]       rom_dev,
  input  logic [2:0]       rom_cfg,
  input  logic [OFF_W-1:0] rom_off,
  output logic             done,
  output logic [7:0]       data,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_addr,
  input  logic             ee_ack,
  input  logic [7:0]       ee_data
);

  logic ee_hit;
  assign ee_hit = ee_req & ee_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      data    <= 8'h00;
      ee_req  <= 1'b0;
      ee_addr <= '0;
    end else begin
      done <= 1'b0;
      if (ee_hit) begin
        ee_req <= 1'b0;
        data   <= ee_data;
        done   <= 1'b1;
      end else if (start) begin
        if (use_ee) begin
          ee_req  <= 1'b1;
          ee_addr <= addr_in;
        end else begin
          data <= rom_byte(rom_dev, rom_cfg, 16'(rom_off));
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/clkcfg_spi_port.sv
module clkcfg_spi_port #(
  parameter int NUM_DEV = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         dev,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_data,
  output logic               accepted,
  output logic               spi_req,
  output logic [NUM_DEV-1:0] spi_cs,
  output logic [15:0]        spi_word,
  input  logic               spi_ack
);

  logic [NUM_DEV-1:0] cs_dec;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dec
    assign cs_dec[i] = (dev == 2'(i));
  end

  assign accepted = spi_req & spi_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_req  <= 1'b0;
      spi_cs   <= '0;
      spi_word <= 16'h0000;
    end else if (accepted) begin
      spi_req <= 1'b0;
      spi_cs  <= '0;
    end else if (start && !spi_req) begin
      spi_req  <= 1'b1;
      spi_cs   <= cs_dec;
      spi_word <= {reg_addr, reg_data};
    end
  end

endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
  import clkcfg_pkg::*;
#(
  parameter int          EE_AW      = 16,
  parameter int          EE_BASE    = 15000,
  parameter int          TBL_STRIDE = 16,
  parameter int          SETTLE_CYC = 16,
  parameter logic [7:0]  SIG_LO     = 8'hA5,
  parameter logic [7:0]  SIG_HI     = 8'hCD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_present,
  input  logic             mod_is_pll,
  input  logic [1:0]       sw,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_addr,
  input  logic             ee_ack,
  input  logic [7:0]       ee_data,
  output logic             spi_req,
  output logic [2:0]       spi_cs,
  output logic [15:0]      spi_word,
  input  logic             spi_ack,
  output logic             done
);

  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int CNT_W = 8;
  localparam int OFF_W = CNT_W + 1;

  typedef enum logic [3:0] {
    S_SETTLE, S_SIG0, S_SIG1, S_NEXT, S_CNT, S_ADDR, S_DATA, S_WR, S_DONE
  } st_e;

  st_e              st;
  logic [SET_W-1:0] settle_cnt;
  logic [1:0]       dev_q;
  logic [CNT_W-1:0] pairs_left;
  logic [OFF_W-1:0] off_q;
  logic [7:0]       addr_b;
  logic             sig_lo_ok;
  logic             sig_ok;
  logic             issued;

  // Named internal events, used by the checker.
  logic        sample_evt;
  logic        wr_evt;
  logic        f_start;
  logic        f_done;
  logic [7:0]  f_data;
  logic        f_use_ee;
  logic [EE_AW-1:0] f_addr;
  plan_t       plan;
  logic        plan_valid;
  logic [2:0]  plan_mask;
  logic [3:0]  mask_x;
  logic        in_fetch;
  logic        spi_start;
  logic [31:0] tbl_addr;

  assign sample_evt = (st == S_SETTLE) && (settle_cnt == SET_W'(SETTLE_CYC - 1));
  assign plan_mask  = plan.dev_mask;
  assign mask_x     = {1'b0, plan.dev_mask};
  assign in_fetch   = (st == S_SIG0) || (st == S_SIG1) || (st == S_CNT) ||
                      (st == S_ADDR) || (st == S_DATA);
  assign f_start    = in_fetch && !issued;
  assign f_use_ee   = ((st == S_SIG0) || (st == S_SIG1)) ? 1'b1 : sig_ok;
  assign spi_start  = (st == S_DATA) && f_done;

  always_comb begin
    tbl_addr = 32'(EE_BASE) + 32'd2 +
               32'(table_index(dev_q, plan.cfg_id)) * 32'(TBL_STRIDE) + 32'(off_q);
    if (st == S_SIG0)      f_addr = EE_AW'(EE_BASE);
    else if (st == S_SIG1) f_addr = EE_AW'(EE_BASE + 1);
    else                   f_addr = tbl_addr[EE_AW-1:0];
  end

  clkcfg_plan u_plan (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (sample_evt),
    .present (mod_present),
    .is_pll  (mod_is_pll),
    .sw      (sw),
    .plan    (plan),
    .valid   (plan_valid)
  );

  clkcfg_fetch #(.EE_AW(EE_AW), .OFF_W(OFF_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (f_start),
    .use_ee  (f_use_ee),
    .addr_in (f_addr),
    .rom_dev (dev_q),
    .rom_cfg (plan.cfg_id),
    .rom_off (off_q),
    .done    (f_done),
    .data    (f_data),
    .ee_req  (ee_req),
    .ee_addr (ee_addr),
    .ee_ack  (ee_ack),
    .ee_data (ee_data)
  );

  clkcfg_spi_port #(.NUM_DEV(NUM_DEV)) u_spi (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (spi_start),
    .dev      (dev_q),
    .reg_addr (addr_b),
    .reg_data (f_data),
    .accepted (wr_evt),
    .spi_req  (spi_req),
    .spi_cs   (spi_cs),
    .spi_word (spi_word),
    .spi_ack  (spi_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_SETTLE;
      settle_cnt <= '0;
      dev_q      <= 2'd0;
      pairs_left <= '0;
      off_q      <= '0;
      addr_b     <= 8'h00;
      sig_lo_ok  <= 1'b0;
      sig_ok     <= 1'b0;
      issued     <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (f_start) issued <= 1'b1;
      if (f_done)  issued <= 1'b0;
      case (st)
        S_SETTLE: begin
          if (sample_evt) st <= S_SIG0;
          else            settle_cnt <= settle_cnt + 1'b1;
        end
        S_SIG0: if (f_done) begin
          sig_lo_ok <= (f_data == SIG_LO);
          st        <= S_SIG1;
        end
        S_SIG1: if (f_done) begin
          sig_ok <= sig_lo_ok && (f_data == SIG_HI);
          st     <= S_NEXT;
        end
        S_NEXT: begin
          if (dev_q == 2'd3) begin
            st   <= S_DONE;
            done <= 1'b1;
          end else if (mask_x[dev_q]) begin
            off_q <= '0;
            st    <= S_CNT;
          end else begin
            dev_q <= dev_q + 2'd1;
          end
        end
        S_CNT: if (f_done) begin
          if (f_data == 8'h00) begin
            dev_q <= dev_q + 2'd1;
            st    <= S_NEXT;
          end else begin
            pairs_left <= f_data;
            off_q      <= OFF_W'(1);
            st         <= S_ADDR;
          end
        end
        S_ADDR: if (f_done) begin
          addr_b <= f_data;
          off_q  <= off_q + 1'b1;
          st     <= S_DATA;
        end
        S_DATA: if (f_done) begin
          off_q <= off_q + 1'b1;
          st    <= S_WR;
        end
        S_WR: if (wr_evt) begin
          if (pairs_left == CNT_W'(1)) begin
            dev_q <= dev_q + 2'd1;
            st    <= S_NEXT;
          end else begin
            pairs_left <= pairs_left - 1'b1;
            st         <= S_ADDR;
          end
        end
        S_DONE: st <= S_DONE;
        default: st <= S_SETTLE;
      endcase
    end
  end

endmodule

// File: rtl/clkcfg_seq_chk.sv
module clkcfg_seq_chk #(
  parameter int EE_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_req,
  input logic             spi_ack,
  input logic [2:0]       spi_cs,
  input logic [15:0]      spi_word,
  input logic             ee_req,
  input logic             ee_ack,
  input logic [EE_AW-1:0] ee_addr,
  input logic             done,
  input logic [2:0]       plan_mask,
  input logic             plan_valid,
  input logic             sample_evt
);

  a_r9_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> ($countones(spi_cs) == 1));

  a_r9_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_req |-> (spi_cs == 3'b000));

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_word) && $stable(spi_cs)));

  a_r10_ee_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

  a_r6_selected_dev: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> (plan_valid && ((spi_cs & plan_mask) != 3'b000)));

  a_r1_sample_once: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !plan_valid);

  a_r2_no_read_before_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> plan_valid);

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!spi_req && !ee_req));

endmodule

bind clkcfg_seq clkcfg_seq_chk #(.EE_AW(EE_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_req    (spi_req),
  .spi_ack    (spi_ack),
  .spi_cs     (spi_cs),
  .spi_word   (spi_word),
  .ee_req     (ee_req),
  .ee_ack     (ee_ack),
  .ee_addr    (ee_addr),
  .done       (done),
  .plan_mask  (plan_mask),
  .plan_valid (plan_valid),
  .sample_evt (sample_evt)
);

// File: tb/test_clkcfg_seq.sv
module test_clkcfg_seq;

  localparam int SETTLE = 16;
  localparam int BASE   = 15000;
  localparam int MEMSZ  = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_present = 1'b0;
  logic        mod_is_pll = 1'b0;
  logic [1:0]  sw = 2'b00;
  logic        ee_req;
  logic [15:0] ee_addr;
  logic        ee_ack = 1'b0;
  logic [7:0]  ee_data = 8'h00;
  logic        spi_req;
  logic [2:0]  spi_cs;
  logic [15:0] spi_word;
  logic        spi_ack = 1'b0;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0]  ee_mem [0:MEMSZ-1];
  logic [2:0]  got_cs [0:63];
  logic [15:0] got_word [0:63];
  logic [2:0]  exp_cs [0:63];
  logic [15:0] exp_word [0:63];
  int n_got, n_exp, n_ee, exp_ee;
  int spi_wait, ee_wait, lat_max;

  always #2.5 clk = ~clk;

  clkcfg_seq #(.SETTLE_CYC(SETTLE)) i_clkcfg_seq (
    .clk(clk), .rst_n(rst_n), .mod_present(mod_present), .mod_is_pll(mod_is_pll),
    .sw(sw), .ee_req(ee_req), .ee_addr(ee_addr), .ee_ack(ee_ack), .ee_data(ee_data),
    .spi_req(spi_req), .spi_cs(spi_cs), .spi_word(spi_word), .spi_ack(spi_ack),
    .done(done)
  );

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog R11: act cycles %0d exp done earlier", cyc);
      summary_and_end();
    end
  end

  // SPI and EEPROM responders, driven at the falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      spi_ack = 1'b0; ee_ack = 1'b0; n_got = 0; n_ee = 0; spi_wait = 0; ee_wait = 0;
    end else begin
      if (spi_ack) spi_ack = 1'b0;
      else if (spi_req) begin
        if (spi_wait == 0) begin
          if (n_got < 64) begin got_cs[n_got] = spi_cs; got_word[n_got] = spi_word; end
          n_got++;
          spi_ack = 1'b1;
          spi_wait = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
        end else spi_wait--;
      end
      if (ee_ack) ee_ack = 1'b0;
      else if (ee_req) begin
        if (ee_wait == 0) begin
          int a;
          a = int'(ee_addr) - BASE;
          ee_data = (a >= 0 && a < MEMSZ) ? ee_mem[a] : 8'hFF;
          n_ee++;
          ee_ack = 1'b1;
          ee_wait = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
        end else ee_wait--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0h exp %0h", tag, what, act, exp);
    end
  endtask

  // sigmode: 0 valid, 1 low byte wrong, 2 high byte wrong
  task automatic fill_ee(input int sigmode);
    for (int i = 0; i < MEMSZ; i++) ee_mem[i] = 8'($urandom);
    for (int t = 0; t < 21; t++) ee_mem[2 + t*16] = 8'($urandom % 8);
    ee_mem[0] = (sigmode == 1) ? 8'hA4 : 8'hA5;
    ee_mem[1] = (sigmode == 2) ? 8'hDC : 8'hCD;
  endtask

  task automatic build_exp(input bit p, input bit pl, input logic [1:0] s, input bit sig_valid);
    int cfg;
    bit [2:0] use_dev;
    if (!p || s == 2'b00) begin cfg = 0; use_dev = 3'b111; end
    else if (pl) begin cfg = 3 + int'(s); use_dev = 3'b111; end
    else begin cfg = int'(s); use_dev = 3'b011; end
    n_exp = 0;
    exp_ee = 2;
    for (int d = 0; d < 3; d++) begin
      if (use_dev[d]) begin
        int t, cnt, base;
        t = d*7 + cfg;
        base = 2 + t*16;
        cnt = sig_valid ? int'(ee_mem[base]) : (t + 1) % 4;
        if (sig_valid) exp_ee += 1 + 2*cnt;
        for (int k = 0; k < cnt; k++) begin
          int a, v;
          if (sig_valid) begin a = ee_mem[base+1+2*k]; v = ee_mem[base+2+2*k]; end
          else begin a = d*64 + cfg*8 + k; v = a ^ 8'h3C; end
          exp_cs[n_exp] = 3'(1 << d);
          exp_word[n_exp] = {a[7:0], v[7:0]};
          n_exp++;
        end
      end
    end
  endtask

  task automatic run_trial(input bit p, input bit pl, input logic [1:0] s, input int sigmode,
                           input bit chg, input int lat, input string tag_wr, input string tag_ee);
    int w;
    lat_max = lat;
    fill_ee(sigmode);
    build_exp(p, pl, s, sigmode == 0);
    @(negedge clk);
    rst_n = 1'b0;
    if (chg) begin mod_present = ~p; mod_is_pll = ~pl; sw = ~s; end
    else begin mod_present = p; mod_is_pll = pl; sw = s; end
    repeat (3) @(negedge clk);
    chk(!done && !spi_req && !ee_req, "R11", "reset state", {done, spi_req, ee_req}, 0);
    rst_n = 1'b1;
    if (chg) begin
      repeat (SETTLE - 2) @(negedge clk);
      mod_present = p; mod_is_pll = pl; sw = s;
      repeat (4) @(negedge clk);
      mod_present = ~p; mod_is_pll = ~pl; sw = ~s;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done, "R11", "done reached", done, 1);
    chk(n_got == n_exp, tag_wr, "write count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_cs[i] == exp_cs[i] && got_word[i] == exp_word[i], tag_wr, "write entry",
          {got_cs[i], got_word[i]}, {exp_cs[i], exp_word[i]});
    end
    chk(n_ee == exp_ee, tag_ee, "eeprom reads", n_ee, exp_ee);
    repeat (6) @(negedge clk);
    chk(done && n_got == n_exp, "R11", "quiet after done", n_got, n_exp);
  endtask

  initial begin
    void'($urandom(32'd7311));
    lat_max = 2;
    // R5: no module, external tables
    run_trial(1'b0, 1'b0, 2'b10, 0, 1'b0, 2, "R5", "R3");
    // R2 / R4: bad signature bytes fall back to ROM
    run_trial(1'b0, 1'b1, 2'b01, 1, 1'b0, 2, "R4", "R2");
    run_trial(1'b0, 1'b0, 2'b00, 2, 1'b0, 3, "R4", "R2");
    // R6: connector module, every switch setting
    for (int s = 0; s < 4; s++) run_trial(1'b1, 1'b0, 2'(s), 0, 1'b0, 2, "R6", "R3");
    // R8: connector C from ROM has an empty RF table
    run_trial(1'b1, 1'b0, 2'b11, 1, 1'b0, 1, "R8", "R2");
    // R7: PLL module, every switch setting, ROM and EEPROM
    for (int s = 0; s < 4; s++) run_trial(1'b1, 1'b1, 2'(s), 0, 1'b0, 2, "R7", "R3");
    for (int s = 0; s < 4; s++) run_trial(1'b1, 1'b1, 2'(s), 2, 1'b0, 1, "R7", "R2");
    // R1: straps move around the sampling edge
    run_trial(1'b1, 1'b0, 2'b01, 0, 1'b1, 2, "R1", "R1");
    run_trial(1'b1, 1'b1, 2'b10, 1, 1'b1, 2, "R1", "R1");
    // R9 / R10: zero-latency responders, back-to-back handshakes
    run_trial(1'b1, 1'b1, 2'b11, 0, 1'b0, 0, "R9", "R10");
    run_trial(1'b0, 1'b0, 2'b00, 0, 1'b0, 0, "R9", "R10");
    // random mix
    for (int n = 0; n < 20; n++) begin
      run_trial(1'($urandom), 1'($urandom), 2'($urandom), int'($urandom % 3),
                1'($urandom % 4 == 0), int'($urandom % 4), "R9", "R10");
    end
    summary_and_end();
  end

endmodule